// File: doc/BRIEF.md
# Coherence Directory Lookup Unit

This unit sits in a home agent and decides, for one coherence request at a time, which caching agents have to be snooped. It first looks the line address up in a small set-associative directory cache. Each entry of that cache holds a presence vector with one bit per caching agent. On a hit the snoop mask is taken from that vector, and the requester's own bit is left out. On a miss the unit waits for the coarse two-bit directory state that the memory read returns alongside the line. It then picks between no snoop, a full broadcast, and shared handling, where only ownership requests need snoops.

The cache keeps lines that migrate between agents. An ownership request that misses allocates an entry whose vector names only the new owner. Later hits refine the vector: an ownership hit narrows it to the requester, and a shared read adds the requester's bit. When an entry has to be replaced, a coarse summary of its vector is written back to the line's in-memory directory bits. A shared read that finds a line in the Local/Invalid state asks for that line to be marked Shared.

Requests enter through a valid/ready handshake. Each decision, together with any directory write request, is presented until the consumer accepts it.

Top module: `coh_dir_lookup`

## Requirements
- R1: While reset is asserted and in the first cycle after it, reqReady is 1, rspValid is 0 and memWrValid is 0.
- R2: A request is accepted on a clock edge where reqValid and reqReady are both 1. reqReady stays 0 until the response is taken (rspValid and rspReady both 1). rspMask, rspKind and the write outputs hold steady while rspValid is 1 and rspReady is 0.
- R3: On a directory cache hit, rspValid rises on the second rising edge after the accepting edge, never on the first.
- R4: A hit snoops exactly the agents whose presence bits are set, minus the requester. rspKind is 01 (targeted) when that mask is non-zero and 00 (no snoop) when it is zero. A hit issues no directory write.
- R5: On a miss, no response is given until memStateValid is sampled high after the lookup cycle. The response appears right after the edge that samples it.
- R6: Miss decisions follow the memory state. 00 (Local/Invalid) gives kind 00 and an all-zero mask. 01 (SnoopAll), and the unused code 11, give kind 10 (broadcast) and an all-ones mask. 10 (Shared) gives a broadcast for an ownership request and kind 00 for a shared read.
- R7: An ownership hit leaves the vector holding only the requester's bit. A shared-read hit ORs the requester's bit into the vector.
- R8: An ownership miss allocates an entry whose vector holds only the requester. A shared-read miss allocates nothing.
- R9: A shared-read miss whose memory state is 00 issues a directory write of state 10 for the request address.
- R10: The set index is the low log2(SETS) address bits. Each set uses an invalid way first, then the least recently used way. Evicting a valid entry writes its address back with a coarse state: 00 for an empty vector, 01 for one bit set, 10 for more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle and able to accept a request |
| reqAddr | input | ADDR_W | Line address of the request |
| reqAgent | input | log2(AGENTS) | Index of the requesting caching agent |
| reqOwn | input | 1 | 1 for an ownership (write) request, 0 for a shared read |
| memStateValid | input | 1 | The in-memory directory state for the missing line is present |
| memState | input | 2 | In-memory directory state: 00 Local/Invalid, 01 SnoopAll, 10 Shared |
| rspValid | output | 1 | Snoop decision present |
| rspReady | input | 1 | Consumer accepts the decision |
| rspMask | output | AGENTS | Agents to snoop |
| rspKind | output | 2 | 00 no snoop, 01 targeted, 10 broadcast |
| memWrValid | output | 1 | Directory write request accompanies the decision |
| memWrAddr | output | ADDR_W | Line address whose in-memory directory bits are rewritten |
| memWrState | output | 2 | New in-memory directory state |

## Verification
A hit answers two edges after the accepting edge. A miss answers one edge after memStateValid is sampled in the waiting phase, so its latency depends on how long the memory read takes. The bench keeps a behavioural model of every set as a most-recently-used-first queue. Before each request it uses that model to decide whether the request will hit, then drives the memory state only after the lookup cycle, with a chosen extra delay. It samples at the falling edge of every cycle in between, checking that rspValid stays low until exactly the predicted cycle, and then compares mask, kind and write request with the model. Responses are sometimes held back with rspReady low to show that the outputs stay stable.

// File: rtl/dir_pkg.sv
package dir_pkg;

  // Coarse directory state stored with every memory line
  typedef enum logic [1:0] {
    MEM_LOCAL    = 2'b00,
    MEM_SNOOPALL = 2'b01,
    MEM_SHARED   = 2'b10,
    MEM_SPARE    = 2'b11
  } memState_e;

  // Kind of snoop decision
  typedef enum logic [1:0] {
    SNP_NONE   = 2'b00,
    SNP_TARGET = 2'b01,
    SNP_BCAST  = 2'b10
  } snoopKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic finishHit;
    logic finishMiss;
  } dirStrobe_t;

endpackage

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rspReady,
  input  logic       memStateValid,
  input  logic       lookupHit,
  output logic       reqReady,
  output logic       rspValid,
  output dirStrobe_t strobe
);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WAITMEM,
    ST_RESP
  } ctrlState_e;

  ctrlState_e state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          nextState      = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lookupHit) begin
          strobe.finishHit = 1'b1;
          nextState        = ST_RESP;
        end else begin
          nextState = ST_WAITMEM;
        end
      end
      ST_WAITMEM: begin
        if (memStateValid) begin
          strobe.finishMiss = 1'b1;
          nextState         = ST_RESP;
        end
      end
      default: begin
        if (rspReady) nextState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);

  // R3
  lookup_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !rspValid);

  // R5
  miss_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITMEM && !memStateValid) |=> !rspValid);

endmodule

// File: rtl/dir_path.sv
module dir_path
  import dir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int AGENTS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dirStrobe_t                strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [$clog2(AGENTS)-1:0] reqAgent,
  input  logic                      reqOwn,
  input  logic [1:0]                memState,
  output logic                      lookupHit,
  output logic [AGENTS-1:0]         rspMask,
  output logic [1:0]                rspKind,
  output logic                      wrPend,
  output logic [ADDR_W-1:0]         memWrAddr,
  output logic [1:0]                memWrState
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int AG_W  = $clog2(AGENTS);

  // Captured request
  logic [ADDR_W-1:0] curAddr;
  logic [AG_W-1:0]   curAgent;
  logic              curOwn;

  // Directory cache storage
  logic [TAG_W-1:0]  tagArr   [SETS][WAYS];
  logic [AGENTS-1:0] vecArr   [SETS][WAYS];
  logic              validArr [SETS][WAYS];
  logic [WAY_W-1:0]  ageArr   [SETS][WAYS];

  logic [IDX_W-1:0]  curSet;
  logic [TAG_W-1:0]  curTag;
  logic [AGENTS-1:0] reqOneHot;
  logic [WAYS-1:0]   matchVec;
  logic [WAY_W-1:0]  hitWay, victimWay, touchWay;
  logic              victimFree, doTouch;

  assign curSet    = curAddr[IDX_W-1:0];
  assign curTag    = curAddr[ADDR_W-1:IDX_W];
  assign reqOneHot = AGENTS'(1) << curAgent;

  function automatic logic [1:0] coarseOf(input logic [AGENTS-1:0] v);
    if ($countones(v) == 0)      return MEM_LOCAL;
    else if ($countones(v) == 1) return MEM_SNOOPALL;
    else                         return MEM_SHARED;
  endfunction

  // Tag compare and way selection
  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      matchVec[w] = validArr[curSet][w] && (tagArr[curSet][w] == curTag);
      if (matchVec[w]) hitWay = WAY_W'(w);
    end
    lookupHit = |matchVec;
  end

  always_comb begin
    victimWay  = '0;
    victimFree = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!validArr[curSet][w] && !victimFree) begin
        victimWay  = WAY_W'(w);
        victimFree = 1'b1;
      end
    end
    if (!victimFree) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ageArr[curSet][w] == WAY_W'(WAYS - 1)) victimWay = WAY_W'(w);
      end
    end
  end

  assign doTouch  = strobe.finishHit || (strobe.finishMiss && curOwn);
  assign touchWay = strobe.finishHit ? hitWay : victimWay;

  // Decisions
  logic [AGENTS-1:0] hitMask, missMask;
  logic [1:0]        hitKind, missKind;
  logic              missWr;
  logic [ADDR_W-1:0] missWrAddr;
  logic [1:0]        missWrState;

  always_comb begin
    hitMask = vecArr[curSet][hitWay] & ~reqOneHot;
    hitKind = (|hitMask) ? SNP_TARGET : SNP_NONE;
    case (memState)
      MEM_LOCAL: begin
        missMask = '0;
        missKind = SNP_NONE;
      end
      MEM_SHARED: begin
        missMask = curOwn ? '1 : '0;
        missKind = curOwn ? SNP_BCAST : SNP_NONE;
      end
      default: begin
        missMask = '1;
        missKind = SNP_BCAST;
      end
    endcase
    missWr      = 1'b0;
    missWrAddr  = curAddr;
    missWrState = MEM_SHARED;
    if (curOwn) begin
      missWr      = !victimFree;
      missWrAddr  = {tagArr[curSet][victimWay], curSet};
      missWrState = coarseOf(vecArr[curSet][victimWay]);
    end else if (memState == MEM_LOCAL) begin
      missWr = 1'b1;
    end
  end

  // Storage update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          validArr[s][w] <= 1'b0;
          tagArr[s][w]   <= '0;
          vecArr[s][w]   <= '0;
          ageArr[s][w]   <= WAY_W'(w);
        end
      end
    end else begin
      if (strobe.finishHit) begin
        vecArr[curSet][hitWay] <= curOwn ? reqOneHot
                                         : (vecArr[curSet][hitWay] | reqOneHot);
      end
      if (strobe.finishMiss && curOwn) begin
        validArr[curSet][victimWay] <= 1'b1;
        tagArr[curSet][victimWay]   <= curTag;
        vecArr[curSet][victimWay]   <= reqOneHot;
      end
      if (doTouch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay)
            ageArr[curSet][w] <= '0;
          else if (ageArr[curSet][w] < ageArr[curSet][touchWay])
            ageArr[curSet][w] <= ageArr[curSet][w] + 1'b1;
        end
      end
    end
  end

  // Request capture and response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr    <= '0;
      curAgent   <= '0;
      curOwn     <= 1'b0;
      rspMask    <= '0;
      rspKind    <= SNP_NONE;
      wrPend     <= 1'b0;
      memWrAddr  <= '0;
      memWrState <= MEM_LOCAL;
    end else begin
      if (strobe.capture) begin
        curAddr  <= reqAddr;
        curAgent <= reqAgent;
        curOwn   <= reqOwn;
        wrPend   <= 1'b0;
      end
      if (strobe.finishHit) begin
        rspMask <= hitMask;
        rspKind <= hitKind;
        wrPend  <= 1'b0;
      end
      if (strobe.finishMiss) begin
        rspMask    <= missMask;
        rspKind    <= missKind;
        wrPend     <= missWr;
        memWrAddr  <= missWrAddr;
        memWrState <= missWrState;
      end
    end
  end

  // R10
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R4
  hit_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.finishHit) |-> ((rspMask & reqOneHot) == '0));

  // R4
  none_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspKind == SNP_NONE) |-> (rspMask == '0));

  // R6
  bcast_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspKind == SNP_BCAST) |-> (&rspMask));

endmodule

// File: rtl/coh_dir_lookup.sv
module coh_dir_lookup
  import dir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int AGENTS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [$clog2(AGENTS)-1:0] reqAgent,
  input  logic                      reqOwn,
  input  logic                      memStateValid,
  input  logic [1:0]                memState,
  output logic                      rspValid,
  input  logic                      rspReady,
  output logic [AGENTS-1:0]         rspMask,
  output logic [1:0]                rspKind,
  output logic                      memWrValid,
  output logic [ADDR_W-1:0]         memWrAddr,
  output logic [1:0]                memWrState
);

  dirStrobe_t strobe;
  logic       lookupHit;
  logic       wrPend;

  dir_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .rspReady      (rspReady),
    .memStateValid (memStateValid),
    .lookupHit     (lookupHit),
    .reqReady      (reqReady),
    .rspValid      (rspValid),
    .strobe        (strobe)
  );

  dir_path #(
    .ADDR_W (ADDR_W),
    .SETS   (SETS),
    .WAYS   (WAYS),
    .AGENTS (AGENTS)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqAgent   (reqAgent),
    .reqOwn     (reqOwn),
    .memState   (memState),
    .lookupHit  (lookupHit),
    .rspMask    (rspMask),
    .rspKind    (rspKind),
    .wrPend     (wrPend),
    .memWrAddr  (memWrAddr),
    .memWrState (memWrState)
  );

  assign memWrValid = rspValid && wrPend;

  // R2
  rsp_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspMask) && $stable(rspKind)
                                 && $stable(memWrValid) && $stable(memWrAddr)));

  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> !reqReady);

endmodule

// File: tb/coh_dir_lookup_bench.sv
`timescale 1ns/1ps
module coh_dir_lookup_bench;

  localparam int NSETS = 4;
  localparam int NWAYS = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, reqOwn;
  logic [15:0] reqAddr;
  logic [2:0]  reqAgent;
  logic        memStateValid;
  logic [1:0]  memState;
  logic        rspValid, rspReady;
  logic [7:0]  rspMask;
  logic [1:0]  rspKind;
  logic        memWrValid;
  logic [15:0] memWrAddr;
  logic [1:0]  memWrState;

  int  total  = 0;
  int  failed = 0;
  bit  done   = 1'b0;

  typedef struct {
    int         tag;
    logic [7:0] vec;
  } ent_t;

  ent_t model [NSETS][$];

  always #5 clk = ~clk;

  coh_dir_lookup u_coh_dir_lookup (
    .clk (clk), .rstN (rstN),
    .reqValid (reqValid), .reqReady (reqReady), .reqAddr (reqAddr),
    .reqAgent (reqAgent), .reqOwn (reqOwn),
    .memStateValid (memStateValid), .memState (memState),
    .rspValid (rspValid), .rspReady (rspReady),
    .rspMask (rspMask), .rspKind (rspKind),
    .memWrValid (memWrValid), .memWrAddr (memWrAddr), .memWrState (memWrState)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int coarse(input logic [7:0] v);
    if ($countones(v) == 0) return 0;
    if ($countones(v) == 1) return 1;
    return 2;
  endfunction

  task automatic doReq(input int addr, input int agent, input bit own,
                       input int mst, input int delay, input bit stall);
    int s = addr % NSETS;
    int tag = addr / NSETS;
    int idx = -1;
    logic [7:0] oh = 8'(1 << agent);
    int eMask, eKind, eWr, eWrAddr, eWrSt;
    string dTag, wTag;
    ent_t e;
    eWr = 0; eWrAddr = 0; eWrSt = 0;
    for (int i = 0; i < model[s].size(); i++) if (model[s][i].tag == tag) idx = i;
    if (idx >= 0) begin
      e = model[s][idx];
      eMask = int'(e.vec & ~oh);
      eKind = (eMask != 0) ? 1 : 0;
      e.vec = own ? oh : (e.vec | oh);
      model[s].delete(idx);
      model[s].push_front(e);
      dTag = "R4 R7 R8";
      wTag = "R4";
    end else begin
      dTag = "R6";
      if (mst == 0) begin eKind = 0; eMask = 0; end
      else if (mst == 2) begin eKind = own ? 2 : 0; eMask = own ? 255 : 0; end
      else begin eKind = 2; eMask = 255; end
      if (own) begin
        wTag = "R10";
        if (model[s].size() == NWAYS) begin
          e = model[s].pop_back();
          eWr = 1; eWrAddr = e.tag * NSETS + s; eWrSt = coarse(e.vec);
        end
        e.tag = tag; e.vec = oh;
        model[s].push_front(e);
      end else begin
        wTag = "R9";
        if (mst == 0) begin eWr = 1; eWrAddr = addr; eWrSt = 2; end
      end
    end
    chk("R2", "reqReady before request", int'(reqReady), 1);
    reqValid = 1'b1; reqAddr = 16'(addr); reqAgent = 3'(agent); reqOwn = own;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    chk("R3", "rspValid in lookup cycle", int'(rspValid), 0);
    chk("R2", "reqReady while busy", int'(reqReady), 0);
    @(posedge clk); @(negedge clk);
    if (idx < 0) begin
      chk("R5", "rspValid while waiting", int'(rspValid), 0);
      for (int d = 0; d < delay; d++) begin
        @(posedge clk); @(negedge clk);
        chk("R5", "rspValid while waiting", int'(rspValid), 0);
      end
      memStateValid = 1'b1; memState = 2'(mst);
      @(posedge clk); @(negedge clk);
      memStateValid = 1'b0;
      chk("R5", "rspValid after memory state", int'(rspValid), 1);
    end else begin
      chk("R3", "rspValid after hit", int'(rspValid), 1);
    end
    chk(dTag, "rspKind", int'(rspKind), eKind);
    chk(dTag, "rspMask", int'(rspMask), eMask);
    chk(wTag, "memWrValid", int'(memWrValid), eWr);
    if (eWr != 0) begin
      chk(wTag, "memWrAddr", int'(memWrAddr), eWrAddr);
      chk(wTag, "memWrState", int'(memWrState), eWrSt);
    end
    if (stall) begin
      @(posedge clk); @(negedge clk);
      chk("R2", "rspValid held", int'(rspValid), 1);
      chk("R2", "rspMask held", int'(rspMask), eMask);
      chk("R2", "reqReady held low", int'(reqReady), 0);
    end
    rspReady = 1'b1;
    @(posedge clk); @(negedge clk);
    rspReady = 1'b0;
    chk("R2", "rspValid after take", int'(rspValid), 0);
    chk("R2", "reqReady after take", int'(reqReady), 1);
    chk("R2", "memWrValid after take", int'(memWrValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqAgent = '0; reqOwn = 1'b0;
    memStateValid = 1'b0; memState = '0; rspReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reqReady in reset", int'(reqReady), 1);
    chk("R1", "rspValid in reset", int'(rspValid), 0);
    chk("R1", "memWrValid in reset", int'(memWrValid), 0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", "rspValid after reset", int'(rspValid), 0);
    chk("R1", "reqReady after reset", int'(reqReady), 1);

    doReq('h10, 1, 1'b0, 0, 0, 1'b0); // R9 read miss on Local, R8 no allocation
    doReq('h10, 2, 1'b0, 2, 3, 1'b0); // R8 still a miss, R6 shared read
    doReq('h10, 3, 1'b1, 2, 1, 1'b0); // R6 shared own broadcast, R8 allocates
    doReq('h10, 5, 1'b0, 0, 0, 1'b1); // R4 hit targets agent 3, R2 stall
    doReq('h10, 3, 1'b0, 0, 0, 1'b0); // R7 vector grew
    doReq('h10, 6, 1'b1, 0, 0, 1'b0); // R7 own hit
    doReq('h10, 6, 1'b0, 0, 0, 1'b0); // R4 empty mask
    doReq('h20, 0, 1'b1, 1, 0, 1'b0); // R6 SnoopAll
    doReq('h30, 2, 1'b1, 3, 2, 1'b0); // R10 evicts 0x10 with single bit
    doReq('h20, 4, 1'b0, 0, 0, 1'b0); // R4 hit refreshes LRU
    doReq('h14, 7, 1'b1, 0, 0, 1'b0); // R10 LRU victim 0x30
    doReq('h40, 1, 1'b1, 1, 0, 1'b1); // R10 evicts 0x20 as Shared
    doReq('h11, 0, 1'b1, 0, 0, 1'b0); // R10 other set, free way
    doReq('h11, 0, 1'b0, 0, 0, 1'b0); // R4 requester only
    doReq('h14, 0, 1'b0, 0, 0, 1'b1); // R4 hit on agent 7

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule